// File: doc/BRIEF.md
# Incremental line ECC updater

This block maintains error protection for a 64-byte cache line built from eight 64-bit chunks. The line carries one SECDED check word that covers all 512 data bits, and each chunk carries its own parity bit. A full-line decode is too slow for ordinary reads, so a read checks only the chunk parity.

When a write replaces a single chunk, the block does not re-encode the whole line. The code is linear, so it encodes only the difference between the old and new chunk, placed at that chunk's position in the line. It XORs the result into the stored check word. It also returns the new chunk's parity in the same cycle.

A separate scrub path takes a whole line and its stored check word. It decodes the syndrome and returns the line and check word one cycle later. A single flipped bit is repaired, and the result is marked clean, corrected or uncorrectable.

Top module: `line_ecc_incr`

## Requirements
- R1: Check word bits [9:0] are Hamming bits. Data bit i (line bit i is bit i%64 of chunk i/64) sits at the i-th position, counting from 1, that is not a power of two, and check bit k is the XOR of all data bits whose position has bit k set. Bit 10 makes the XOR of all 512 data bits and all 11 check-word bits zero.
- R2: In the same cycle, `wr_word_out` equals `wr_word_in` XOR the R1 check word of the line that is zero except for `wr_old ^ wr_new` at chunk `wr_idx`. For a consistent input word, this equals a full re-encode of the updated line.
- R3: `wr_par_out` is the XOR of the 64 bits of `wr_new`.
- R4: When `wr_old` equals `wr_new`, `wr_word_out` equals `wr_word_in`.
- R5: `rd_par_err` is 1 exactly when the XOR of `rd_data` and `rd_par` is 1.
- R6: `scr_vld` is high in the cycle after each cycle in which `chk_valid` is high, and low otherwise.
- R7: A line whose syndrome is zero and whose overall parity matches is returned unchanged with `scr_clean` set.
- R8: A single flipped data bit is restored in `scr_line` with `scr_corr` set.
- R9: A single flipped check-word bit, including bit 10, is restored in `scr_word`, with the line unchanged and `scr_corr` set.
- R10: Any two flipped bits give `scr_uncorr`, with the line and word returned unchanged.
- R11: A parity mismatch whose syndrome exceeds the highest used position (522) gives `scr_uncorr` with no bit changed.
- R12: After reset `scr_vld` and all three flags are 0. While `scr_vld` is high, exactly one flag is set. While it is low, none is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_idx | input | 3 | Index of the chunk being written |
| wr_old | input | 64 | Chunk contents before the write |
| wr_new | input | 64 | Chunk contents after the write |
| wr_word_in | input | 11 | Stored check word before the write |
| wr_word_out | output | 11 | Updated check word |
| wr_par_out | output | 1 | Parity bit for the new chunk |
| rd_data | input | 64 | Chunk being read |
| rd_par | input | 1 | Stored parity of the chunk being read |
| rd_par_err | output | 1 | Read parity mismatch |
| chk_valid | input | 1 | Scrub request |
| chk_line | input | 512 | Line to scrub |
| chk_word | input | 11 | Stored check word of that line |
| scr_vld | output | 1 | Scrub result valid |
| scr_line | output | 512 | Line after correction |
| scr_word | output | 11 | Check word after correction |
| scr_clean | output | 1 | No error found |
| scr_corr | output | 1 | Single error corrected |
| scr_uncorr | output | 1 | Error that cannot be corrected |

## Verification
The bench compares the incremental word against an independent full re-encode over many random lines, random chunks and random new data. A wrong chunk offset or a missing overall-parity term would show up as a mismatch here. Single errors are placed at the first and last data bits, at both sides of a chunk boundary, at the top Hamming bit and at the overall bit. An off-by-one position map would flip the neighbouring bit, and a decoder that ignores bit 10 would flag a clean line as uncorrectable. Double errors and an odd error pattern whose syndrome falls past position 522 must pass through unaltered. A decoder that trusts any nonzero syndrome would corrupt a bit in these cases.

// File: rtl/line_ecc_pkg.sv
package line_ecc_pkg;

  // Hamming bits needed so that 2^r covers data, check and zero positions.
  function automatic int ham_bits(input int data_w);
    int r;
    r = 1;
    while ((1 << r) < data_w + r + 1) r++;
    return r;
  endfunction

  // Codeword position (from 1) of data bit idx, skipping powers of two.
  function automatic int ham_pos(input int idx);
    int p;
    p = idx + 1;
    for (int k = 0; k < 30; k++)
      if ((1 << k) <= p) p++;
    return p;
  endfunction

endpackage

// File: rtl/line_ham_enc.sv
module line_ham_enc
  import line_ecc_pkg::*;
#(
  parameter int LINE_W = 512,
  parameter int HAM_W  = ham_bits(LINE_W)
) (
  input  logic [LINE_W-1:0] data,
  output logic [HAM_W:0]    word
);

  logic [HAM_W-1:0] contrib [LINE_W];

  for (genvar g = 0; g < LINE_W; g++) begin : g_col
    localparam logic [HAM_W-1:0] COL = HAM_W'(ham_pos(g));
    assign contrib[g] = data[g] ? COL : '0;
  end

  logic [HAM_W-1:0] ham;

  always_comb begin
    ham = '0;
    for (int i = 0; i < LINE_W; i++) ham ^= contrib[i];
  end

  assign word = {(^data) ^ (^ham), ham};

endmodule

// File: rtl/line_chunk_upd.sv
module line_chunk_upd
  import line_ecc_pkg::*;
#(
  parameter int CHUNK_W  = 64,
  parameter int N_CHUNKS = 8,
  parameter int LINE_W   = CHUNK_W * N_CHUNKS,
  parameter int IDX_W    = $clog2(N_CHUNKS),
  parameter int CHK_W    = ham_bits(LINE_W) + 1
) (
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [CHUNK_W-1:0] wr_old,
  input  logic [CHUNK_W-1:0] wr_new,
  input  logic [CHK_W-1:0]   wr_word_in,
  output logic [CHK_W-1:0]   wr_word_out,
  output logic               wr_par_out,
  input  logic [CHUNK_W-1:0] rd_data,
  input  logic               rd_par,
  output logic               rd_par_err
);

  logic [CHUNK_W-1:0] delta;
  logic [LINE_W-1:0]  delta_line;
  logic [CHK_W-1:0]   delta_word;

  always_comb begin
    delta      = wr_old ^ wr_new;
    delta_line = LINE_W'(delta) << (int'(wr_idx) * CHUNK_W);
  end

  line_ham_enc #(.LINE_W(LINE_W), .HAM_W(CHK_W - 1)) delta_enc_i (
    .data (delta_line),
    .word (delta_word)
  );

  assign wr_word_out = wr_word_in ^ delta_word;
  assign wr_par_out  = ^wr_new;
  assign rd_par_err  = (^rd_data) ^ rd_par;

endmodule

// File: rtl/line_scrub.sv
module line_scrub
  import line_ecc_pkg::*;
#(
  parameter int LINE_W = 512,
  parameter int HAM_W  = ham_bits(LINE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_valid,
  input  logic [LINE_W-1:0] chk_line,
  input  logic [HAM_W:0]    chk_word,
  output logic              scr_vld,
  output logic [LINE_W-1:0] scr_line,
  output logic [HAM_W:0]    scr_word,
  output logic              scr_clean,
  output logic              scr_corr,
  output logic              scr_uncorr
);

  localparam int LAST_POS = ham_pos(LINE_W - 1);

  logic [HAM_W:0]    re_word;
  logic [HAM_W-1:0]  syn;
  logic              par_err, in_range;
  logic              clean_d, corr_d, uncorr_d;
  logic [LINE_W-1:0] fix_line;
  logic [HAM_W:0]    fix_word;

  line_ham_enc #(.LINE_W(LINE_W), .HAM_W(HAM_W)) re_enc_i (
    .data (chk_line),
    .word (re_word)
  );

  always_comb begin
    syn      = chk_word[HAM_W-1:0] ^ re_word[HAM_W-1:0];
    par_err  = (^chk_line) ^ (^chk_word);
    in_range = int'(syn) <= LAST_POS;
    clean_d  = (syn == '0) && !par_err;
    corr_d   = par_err && in_range;
    uncorr_d = !clean_d && !corr_d;
  end

  for (genvar g = 0; g < LINE_W; g++) begin : g_fix_d
    localparam logic [HAM_W-1:0] COL = HAM_W'(ham_pos(g));
    assign fix_line[g] = corr_d && (syn == COL);
  end

  for (genvar k = 0; k < HAM_W; k++) begin : g_fix_c
    assign fix_word[k] = corr_d && (syn == HAM_W'(1 << k));
  end
  assign fix_word[HAM_W] = corr_d && (syn == '0);

  // Result flags: reset state holds no result.
  logic vld_d;
  logic [2:0] flags_d, flags_q;

  always_comb begin
    vld_d   = chk_valid;
    flags_d = chk_valid ? {uncorr_d, corr_d, clean_d} : 3'b000;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scr_vld <= 1'b0;
      flags_q <= 3'b000;
    end else begin
      scr_vld <= vld_d;
      flags_q <= flags_d;
    end
  end

  // Payload registers: enabled by the request, no reset needed.
  always_ff @(posedge clk) begin
    if (chk_valid) begin
      scr_line <= chk_line ^ fix_line;
      scr_word <= chk_word ^ fix_word;
    end
  end

  assign scr_clean  = flags_q[0];
  assign scr_corr   = flags_q[1];
  assign scr_uncorr = flags_q[2];

endmodule

// File: rtl/line_ecc_incr.sv
module line_ecc_incr
  import line_ecc_pkg::*;
#(
  parameter  int CHUNK_W  = 64,
  parameter  int N_CHUNKS = 8,
  localparam int LINE_W   = CHUNK_W * N_CHUNKS,
  localparam int IDX_W    = $clog2(N_CHUNKS),
  localparam int HAM_W    = ham_bits(LINE_W),
  localparam int CHK_W    = HAM_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [CHUNK_W-1:0] wr_old,
  input  logic [CHUNK_W-1:0] wr_new,
  input  logic [CHK_W-1:0]   wr_word_in,
  output logic [CHK_W-1:0]   wr_word_out,
  output logic               wr_par_out,
  input  logic [CHUNK_W-1:0] rd_data,
  input  logic               rd_par,
  output logic               rd_par_err,
  input  logic               chk_valid,
  input  logic [LINE_W-1:0]  chk_line,
  input  logic [CHK_W-1:0]   chk_word,
  output logic               scr_vld,
  output logic [LINE_W-1:0]  scr_line,
  output logic [CHK_W-1:0]   scr_word,
  output logic               scr_clean,
  output logic               scr_corr,
  output logic               scr_uncorr
);

  line_chunk_upd #(
    .CHUNK_W(CHUNK_W), .N_CHUNKS(N_CHUNKS), .LINE_W(LINE_W),
    .IDX_W(IDX_W), .CHK_W(CHK_W)
  ) upd_i (
    .wr_idx      (wr_idx),
    .wr_old      (wr_old),
    .wr_new      (wr_new),
    .wr_word_in  (wr_word_in),
    .wr_word_out (wr_word_out),
    .wr_par_out  (wr_par_out),
    .rd_data     (rd_data),
    .rd_par      (rd_par),
    .rd_par_err  (rd_par_err)
  );

  line_scrub #(.LINE_W(LINE_W), .HAM_W(HAM_W)) scrub_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .chk_valid  (chk_valid),
    .chk_line   (chk_line),
    .chk_word   (chk_word),
    .scr_vld    (scr_vld),
    .scr_line   (scr_line),
    .scr_word   (scr_word),
    .scr_clean  (scr_clean),
    .scr_corr   (scr_corr),
    .scr_uncorr (scr_uncorr)
  );

endmodule

module line_ecc_incr_chk #(
  parameter int CHUNK_W = 64,
  parameter int LINE_W  = 512,
  parameter int CHK_W   = 11
) (
  input logic               clk,
  input logic               rst_n,
  input logic [CHUNK_W-1:0] wr_old,
  input logic [CHUNK_W-1:0] wr_new,
  input logic [CHK_W-1:0]   wr_word_in,
  input logic [CHK_W-1:0]   wr_word_out,
  input logic               chk_valid,
  input logic [LINE_W-1:0]  chk_line,
  input logic [CHK_W-1:0]   chk_word,
  input logic               scr_vld,
  input logic [LINE_W-1:0]  scr_line,
  input logic [CHK_W-1:0]   scr_word,
  input logic               scr_clean,
  input logic               scr_corr,
  input logic               scr_uncorr
);

  a_r4_zero_delta: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_old == wr_new) |-> (wr_word_out == wr_word_in));

  a_r6_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> scr_vld);

  a_r6_vld_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> !scr_vld);

  a_r7_clean_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (scr_vld && scr_clean) |->
      (scr_line == $past(chk_line) && scr_word == $past(chk_word)));

  a_r8_single_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (scr_vld && scr_corr) |->
      ($countones({scr_line ^ $past(chk_line), scr_word ^ $past(chk_word)}) == 1));

  a_r10_uncorr_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (scr_vld && scr_uncorr) |->
      (scr_line == $past(chk_line) && scr_word == $past(chk_word)));

  a_r12_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    scr_vld |-> ($countones({scr_clean, scr_corr, scr_uncorr}) == 1));

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !scr_vld |-> !(scr_clean || scr_corr || scr_uncorr));

endmodule

bind line_ecc_incr line_ecc_incr_chk #(
  .CHUNK_W(CHUNK_W), .LINE_W(LINE_W), .CHK_W(CHK_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_old      (wr_old),
  .wr_new      (wr_new),
  .wr_word_in  (wr_word_in),
  .wr_word_out (wr_word_out),
  .chk_valid   (chk_valid),
  .chk_line    (chk_line),
  .chk_word    (chk_word),
  .scr_vld     (scr_vld),
  .scr_line    (scr_line),
  .scr_word    (scr_word),
  .scr_clean   (scr_clean),
  .scr_corr    (scr_corr),
  .scr_uncorr  (scr_uncorr)
);

// File: tb/line_ecc_incr_tb.sv
`timescale 1ns/1ps
module line_ecc_incr_tb_top;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [2:0]   wr_idx;
  logic [63:0]  wr_old, wr_new;
  logic [10:0]  wr_word_in;
  logic [10:0]  wr_word_out;
  logic         wr_par_out;
  logic [63:0]  rd_data;
  logic         rd_par;
  logic         rd_par_err;
  logic         chk_valid;
  logic [511:0] chk_line;
  logic [10:0]  chk_word;
  logic         scr_vld;
  logic [511:0] scr_line;
  logic [10:0]  scr_word;
  logic         scr_clean, scr_corr, scr_uncorr;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  line_ecc_incr dut_i (
    .clk(clk), .rst_n(rst_n), .wr_idx(wr_idx), .wr_old(wr_old), .wr_new(wr_new),
    .wr_word_in(wr_word_in), .wr_word_out(wr_word_out), .wr_par_out(wr_par_out),
    .rd_data(rd_data), .rd_par(rd_par), .rd_par_err(rd_par_err),
    .chk_valid(chk_valid), .chk_line(chk_line), .chk_word(chk_word),
    .scr_vld(scr_vld), .scr_line(scr_line), .scr_word(scr_word),
    .scr_clean(scr_clean), .scr_corr(scr_corr), .scr_uncorr(scr_uncorr)
  );

  // Reference encoder written from R1: walk positions, skip powers of two.
  function automatic logic [10:0] ref_encode(input logic [511:0] ln);
    logic [9:0] c;
    int di;
    int pos;
    c = '0; di = 0; pos = 0;
    while (di < 512) begin
      pos++;
      if ((pos & (pos - 1)) != 0) begin
        if (ln[di]) c ^= pos[9:0];
        di++;
      end
    end
    return {(^ln) ^ (^c), c};
  endfunction

  function automatic logic [511:0] rand_line();
    logic [511:0] ln;
    for (int w = 0; w < 16; w++) ln[w*32 +: 32] = $urandom;
    return ln;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [575:0] act, input logic [575:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic scrub(input logic [511:0] ln, input logic [10:0] wd,
                       output logic [511:0] lo, output logic [10:0] wo,
                       output logic [2:0] fl);
    @(negedge clk);
    chk_valid = 1'b1; chk_line = ln; chk_word = wd;
    @(negedge clk);
    check(scr_vld === 1'b1, "R6 valid after request", 576'(scr_vld), 576'(1));
    lo = scr_line; wo = scr_word; fl = {scr_uncorr, scr_corr, scr_clean};
    chk_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; chk_valid = 1'b0; chk_line = '0; chk_word = '0;
    wr_idx = '0; wr_old = '0; wr_new = '0; wr_word_in = '0;
    rd_data = '0; rd_par = 1'b0;
    repeat (3) @(negedge clk);
    check({scr_vld, scr_clean, scr_corr, scr_uncorr} === 4'b0, "R12 reset state",
          576'({scr_vld, scr_clean, scr_corr, scr_uncorr}), 576'(0));
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_incr_random();
    int bad_word = 0, bad_par = 0;
    for (int n = 0; n < 300; n++) begin
      logic [511:0] ln, ln2;
      logic [2:0]   ix;
      logic [63:0]  nv;
      ln = rand_line(); ix = 3'($urandom); nv = {$urandom, $urandom};
      if (n < 8) ix = 3'(n);
      ln2 = ln; ln2[ix*64 +: 64] = nv;
      @(negedge clk);
      wr_idx = ix; wr_old = ln[ix*64 +: 64]; wr_new = nv; wr_word_in = ref_encode(ln);
      #1;
      if (wr_word_out !== ref_encode(ln2)) begin
        bad_word++;
        check(1'b0, "R2 incremental vs full re-encode", 576'(wr_word_out), 576'(ref_encode(ln2)));
      end
      if (wr_par_out !== ^nv) begin
        bad_par++;
        check(1'b0, "R3 chunk parity", 576'(wr_par_out), 576'(^nv));
      end
    end
    check(bad_word == 0, "R2 all random writes match R1 encode", 576'(bad_word), 576'(0));
    check(bad_par == 0, "R3 all chunk parities", 576'(bad_par), 576'(0));
  endtask

  task automatic t_zero_delta();
    logic [10:0] w;
    w = 11'($urandom);
    @(negedge clk);
    wr_idx = 3'd5; wr_old = 64'hdead_beef_0123_4567; wr_new = wr_old; wr_word_in = w;
    #1;
    check(wr_word_out === w, "R4 unchanged chunk keeps word", 576'(wr_word_out), 576'(w));
  endtask

  task automatic t_read_par();
    @(negedge clk);
    rd_data = 64'h0000_0000_0000_0007; rd_par = 1'b1;
    #1;
    check(rd_par_err === 1'b0, "R5 good parity", 576'(rd_par_err), 576'(0));
    rd_par = 1'b0;
    #1;
    check(rd_par_err === 1'b1, "R5 bad parity", 576'(rd_par_err), 576'(1));
  endtask

  task automatic t_clean();
    logic [511:0] ln, lo;
    logic [10:0]  wo;
    logic [2:0]   fl;
    ln = rand_line();
    scrub(ln, ref_encode(ln), lo, wo, fl);
    check(fl === 3'b001, "R7 clean flag", 576'(fl), 576'(1));
    check({lo, wo} === {ln, ref_encode(ln)}, "R7 clean pass-through",
          576'({lo, wo}), 576'({ln, ref_encode(ln)}));
    @(negedge clk);
    check(scr_vld === 1'b0 && {scr_uncorr, scr_corr, scr_clean} === 3'b0,
          "R6 R12 idle after one result", 576'({scr_vld, scr_uncorr, scr_corr, scr_clean}), 576'(0));
  endtask

  task automatic t_single_data();
    int bits [6] = '{0, 63, 64, 255, 448, 511};
    foreach (bits[j]) begin
      logic [511:0] ln, bad, lo;
      logic [10:0]  wo, w;
      logic [2:0]   fl;
      ln = rand_line(); w = ref_encode(ln); bad = ln; bad[bits[j]] = ~bad[bits[j]];
      scrub(bad, w, lo, wo, fl);
      check(fl === 3'b010, "R8 single data error flag", 576'(fl), 576'(2));
      check({lo, wo} === {ln, w}, "R8 single data error restored", 576'({lo, wo}), 576'({ln, w}));
    end
  endtask

  task automatic t_single_check();
    int kb [4] = '{0, 5, 9, 10};
    foreach (kb[j]) begin
      logic [511:0] ln, lo;
      logic [10:0]  wo, w, bw;
      logic [2:0]   fl;
      ln = rand_line(); w = ref_encode(ln); bw = w; bw[kb[j]] = ~bw[kb[j]];
      scrub(ln, bw, lo, wo, fl);
      check(fl === 3'b010, "R9 check-bit error flag", 576'(fl), 576'(2));
      check({lo, wo} === {ln, w}, "R9 check-bit restored", 576'({lo, wo}), 576'({ln, w}));
    end
  endtask

  task automatic t_double();
    logic [511:0] ln, bad, lo;
    logic [10:0]  wo, w, bw;
    logic [2:0]   fl;
    ln = rand_line(); w = ref_encode(ln);
    bad = ln; bad[3] = ~bad[3]; bad[400] = ~bad[400];
    scrub(bad, w, lo, wo, fl);
    check(fl === 3'b100, "R10 two data bits flag", 576'(fl), 576'(4));
    check({lo, wo} === {bad, w}, "R10 two data bits unchanged", 576'({lo, wo}), 576'({bad, w}));
    bad = ln; bad[100] = ~bad[100]; bw = w; bw[10] = ~bw[10];
    scrub(bad, bw, lo, wo, fl);
    check(fl === 3'b100, "R10 data plus overall bit flag", 576'(fl), 576'(4));
    check({lo, wo} === {bad, bw}, "R10 data plus overall unchanged", 576'({lo, wo}), 576'({bad, bw}));
  endtask

  task automatic t_out_of_range();
    logic [511:0] ln, lo;
    logic [10:0]  wo, w, bw;
    logic [2:0]   fl;
    ln = rand_line(); w = ref_encode(ln);
    bw = w ^ 11'b010_0011_0000;  // syndrome 512+32+16 = 560, odd count
    scrub(ln, bw, lo, wo, fl);
    check(fl === 3'b100, "R11 syndrome past last position", 576'(fl), 576'(4));
    check({lo, wo} === {ln, bw}, "R11 nothing flipped", 576'({lo, wo}), 576'({ln, bw}));
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    t_reset();
    t_incr_random();
    t_zero_delta();
    t_read_par();
    t_clean();
    t_single_data();
    t_single_check();
    t_double();
    t_out_of_range();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule